// File: doc/BRIEF.md
# Serial Port Configuration Register File with Overlaid Address

This block holds the settings for a serial transmitter and receiver. It stores a 12-bit baud divisor, a seven-bit frame-format register and a one-bit extension of the data-size field. It turns them into registered, decoded fields for the serial datapath. The low byte of the divisor and the size extension each have their own bus address. The upper four divisor bits and the frame-format register share a single address.

On a write to the shared address, bit 7 of the write data picks the target. When it is set, the frame format is loaded. When it is clear, the divisor's upper bits are loaded. Reads of the shared address alternate. A lone read, or the first of a run of back-to-back reads, returns the divisor's upper bits. A read in the very next clock returns the frame format. Any cycle that is not a shared read ends the run.

Read data is registered and appears one clock after the read strobe. The decoded fields follow a write within two clock edges.

Top module: `shared_addr_cfg_regs`

## Requirements
- R1: After synchronous reset, the register values are as follows. The baud divisor is 0. The frame format is 0x06: asynchronous, no parity (parity code 00), one stop bit, 8 data bits and clock polarity 0. The size extension bit is 0 and the read data is 0.
- R2: A write to the shared address (default 2) with wdata[7]=1 loads wdata[6:0] into the frame format and leaves the baud divisor unchanged.
- R3: A write to the shared address with wdata[7]=0 loads wdata[3:0] into divisor bits 11:8. wdata[6:4] are ignored and the frame format is unchanged.
- R4: A write to the low-divisor address (default 0) loads wdata[7:0] into divisor bits 7:0, so the full divisor spans 0 to 4095.
- R5: A read of the shared address while no run is open returns {4'b0, divisor[11:8]} on rdata one clock after the read strobe.
- R6: A shared read in the clock right after a read that returned the divisor returns {1'b1, frame[6:0]}. A third back-to-back shared read returns the divisor again.
- R7: Any cycle without a shared read closes the run, so the next shared read returns the divisor. Such cycles are idle cycles, writes, and reads of other addresses.
- R8: The frame format decodes as follows. Bit 6 is the mode (0 = asynchronous). Bits 5:4 are the parity code (00 none, 10 even, 11 odd). Bit 3 is two stop bits when 1. Bits 2:1 are the low size bits. Bit 0 is the clock polarity. Writing 0xAE gives asynchronous mode, even parity, two stop bits and 8 data bits.
- R9: The data size uses {ext, frame[2:1]}. The codes are 000→5, 001→6, 010→7, 011→8 and 111→9 bits. Reserved codes give 8.
- R10: The control address (default 1) stores only wdata[2] as the size extension and reads back as {5'b0, ext, 2'b0}. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid one clock after the strobe |
| baud_div | output | DIV_W | Baud divisor |
| sync_mode | output | 1 | 1 = synchronous mode |
| parity_mode | output | 2 | Parity code |
| two_stop | output | 1 | 1 = two stop bits |
| data_bits | output | 4 | Decoded data size, 5 to 9 |
| clk_pol | output | 1 | Synchronous clock polarity |

## Verification
Some properties are checked on every cycle. A bit-7-steered write must leave the other overlaid register untouched. A shared read with no run open must return the divisor's upper bits one clock later. A read that continues a run must return data with bit 7 set. The decoded size must stay within 5 to 9 bits. The bench's scenarios are needed for the rest: the exact alternation across three or more back-to-back reads, and the closing of a run by idle cycles, writes or other addresses. The scenarios also cover the full size encoding table and the exact field values produced by a frame-format write.

// File: rtl/cfg_regs_pkg.sv
package cfg_regs_pkg;

  typedef struct packed {
    logic       sync_sel;
    logic [1:0] par_code;
    logic       stop_two;
    logic [1:0] size_lo;
    logic       pol;
  } frame_t;

  localparam frame_t FRAME_RST = '{sync_sel: 1'b0, par_code: 2'b00,
                                   stop_two: 1'b0, size_lo: 2'b11, pol: 1'b0};

  function automatic logic [3:0] size_to_bits(input logic [2:0] code);
    case (code)
      3'b000:  size_to_bits = 4'd5;
      3'b001:  size_to_bits = 4'd6;
      3'b010:  size_to_bits = 4'd7;
      3'b111:  size_to_bits = 4'd9;
      default: size_to_bits = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_regs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DIV_W = 12,
  parameter int SEL_BIT = 7,
  parameter int CTRL_SZ_BIT = 2,
  parameter logic [ADDR_W-1:0] ADDR_DIVLO = 2'd0,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 2'd1,
  parameter logic [ADDR_W-1:0] ADDR_SHARED = 2'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [DIV_W-1:0]  div_q,
  output frame_t            frame_q,
  output logic              sz_hi_q
);
  localparam int HI_W = DIV_W - 8;

  logic wr_shared;
  assign wr_shared = wr_en && (addr == ADDR_SHARED);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      frame_q <= FRAME_RST;
      sz_hi_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADDR_DIVLO) div_q[7:0] <= wdata;
      if (addr == ADDR_CTRL)  sz_hi_q <= wdata[CTRL_SZ_BIT];
      if (wr_shared) begin
        if (wdata[SEL_BIT]) frame_q <= frame_t'(wdata[6:0]);
        else                div_q[DIV_W-1:8] <= wdata[HI_W-1:0];
      end
    end
  end

  assert_div_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_shared && wdata[SEL_BIT]) |=> $stable(div_q));
  assert_frame_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_shared && !wdata[SEL_BIT]) |=> $stable(frame_q));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_regs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DIV_W = 12,
  parameter int CTRL_SZ_BIT = 2,
  parameter logic [ADDR_W-1:0] ADDR_DIVLO = 2'd0,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 2'd1,
  parameter logic [ADDR_W-1:0] ADDR_SHARED = 2'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DIV_W-1:0]  div_q,
  input  frame_t            frame_q,
  input  logic              sz_hi_q,
  output logic [7:0]        rdata
);
  localparam int HI_W = DIV_W - 8;

  logic       rd_shared;
  logic       run_open;
  logic [7:0] ctrl_view;
  logic [7:0] rd_next;

  assign rd_shared = rd_en && !wr_en && (addr == ADDR_SHARED);

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_SZ_BIT] = sz_hi_q;
  end

  always_comb begin
    rd_next = '0;
    if (rd_shared) begin
      if (run_open) rd_next = {1'b1, frame_q};
      else          rd_next = {{(8-HI_W){1'b0}}, div_q[DIV_W-1:8]};
    end else if (rd_en && addr == ADDR_DIVLO) begin
      rd_next = div_q[7:0];
    end else if (rd_en && addr == ADDR_CTRL) begin
      rd_next = ctrl_view;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_open <= 1'b0;
      rdata    <= '0;
    end else begin
      run_open <= rd_shared && !run_open;
      if (rd_en) rdata <= rd_next;
    end
  end

  assert_hi_read_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_shared && !run_open) |=>
      (rdata == {{(8-HI_W){1'b0}}, $past(div_q[DIV_W-1:8])}));
  assert_frame_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_shared && run_open) |=> rdata[7]);

endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
  import cfg_regs_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_q,
  input  frame_t           frame_q,
  input  logic             sz_hi_q,
  output logic [DIV_W-1:0] baud_div,
  output logic             sync_mode,
  output logic [1:0]       parity_mode,
  output logic             two_stop,
  output logic [3:0]       data_bits,
  output logic             clk_pol
);
  always_ff @(posedge clk) begin
    if (rst) begin
      baud_div    <= '0;
      sync_mode   <= FRAME_RST.sync_sel;
      parity_mode <= FRAME_RST.par_code;
      two_stop    <= FRAME_RST.stop_two;
      data_bits   <= size_to_bits({1'b0, FRAME_RST.size_lo});
      clk_pol     <= FRAME_RST.pol;
    end else begin
      baud_div    <= div_q;
      sync_mode   <= frame_q.sync_sel;
      parity_mode <= frame_q.par_code;
      two_stop    <= frame_q.stop_two;
      data_bits   <= size_to_bits({sz_hi_q, frame_q.size_lo});
      clk_pol     <= frame_q.pol;
    end
  end

  assert_size_range_R9: assert property (@(posedge clk) disable iff (rst)
    (data_bits >= 4'd5) && (data_bits <= 4'd9));
  assert_ninebit_R9: assert property (@(posedge clk) disable iff (rst)
    (sz_hi_q && frame_q.size_lo == 2'b11) |=> (data_bits == 4'd9));

endmodule

// File: rtl/shared_addr_cfg_regs.sv
module shared_addr_cfg_regs
  import cfg_regs_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DIV_W = 12,
  parameter int SEL_BIT = 7,
  parameter int CTRL_SZ_BIT = 2,
  parameter logic [ADDR_W-1:0] ADDR_DIVLO = 2'd0,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 2'd1,
  parameter logic [ADDR_W-1:0] ADDR_SHARED = 2'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [DIV_W-1:0]  baud_div,
  output logic              sync_mode,
  output logic [1:0]        parity_mode,
  output logic              two_stop,
  output logic [3:0]        data_bits,
  output logic              clk_pol
);
  logic [DIV_W-1:0] div_q;
  frame_t           frame_q;
  logic             sz_hi_q;

  cfg_reg_bank #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .SEL_BIT(SEL_BIT), .CTRL_SZ_BIT(CTRL_SZ_BIT),
    .ADDR_DIVLO(ADDR_DIVLO), .ADDR_CTRL(ADDR_CTRL), .ADDR_SHARED(ADDR_SHARED)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .div_q(div_q), .frame_q(frame_q), .sz_hi_q(sz_hi_q)
  );

  cfg_read_mux #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CTRL_SZ_BIT(CTRL_SZ_BIT),
    .ADDR_DIVLO(ADDR_DIVLO), .ADDR_CTRL(ADDR_CTRL), .ADDR_SHARED(ADDR_SHARED)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd_en), .wr_en(bus_wr_en), .addr(bus_addr),
    .div_q(div_q), .frame_q(frame_q), .sz_hi_q(sz_hi_q), .rdata(bus_rdata)
  );

  cfg_field_decode #(.DIV_W(DIV_W)) u_dec (
    .clk(clk), .rst(rst), .div_q(div_q), .frame_q(frame_q), .sz_hi_q(sz_hi_q),
    .baud_div(baud_div), .sync_mode(sync_mode), .parity_mode(parity_mode),
    .two_stop(two_stop), .data_bits(data_bits), .clk_pol(clk_pol)
  );

endmodule

// File: tb/shared_addr_cfg_regs_bench.sv
module shared_addr_cfg_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr_en = 1'b0;
  logic       bus_rd_en = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [11:0] baud_div;
  logic       sync_mode;
  logic [1:0] parity_mode;
  logic       two_stop;
  logic [3:0] data_bits;
  logic       clk_pol;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shared_addr_cfg_regs u_shared_addr_cfg_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_div(baud_div), .sync_mode(sync_mode), .parity_mode(parity_mode),
    .two_stop(two_stop), .data_bits(data_bits), .clk_pol(clk_pol)
  );

  // entry: {wr, rd, addr[1:0], wdata[7:0], expected rdata[7:0]}
  localparam int NV = 18;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'd0, 8'h67, 8'h00},  // R4 low divisor
    {1'b1, 1'b0, 2'd2, 8'h05, 8'h00},  // R3 high divisor
    {1'b0, 1'b1, 2'd2, 8'h00, 8'h05},  // R5
    {1'b0, 1'b1, 2'd2, 8'h00, 8'h86},  // R6 frame on second read
    {1'b0, 1'b1, 2'd2, 8'h00, 8'h05},  // R6 third read back to divisor
    {1'b0, 1'b0, 2'd0, 8'h00, 8'h00},  // idle
    {1'b0, 1'b1, 2'd2, 8'h00, 8'h05},  // R7 after idle
    {1'b0, 1'b1, 2'd0, 8'h00, 8'h67},  // R4 readback, R7 other address
    {1'b0, 1'b1, 2'd2, 8'h00, 8'h05},  // R7
    {1'b1, 1'b0, 2'd2, 8'hAE, 8'h00},  // R2 frame write
    {1'b0, 1'b1, 2'd2, 8'h00, 8'h05},  // R2 divisor kept, R7 after write
    {1'b0, 1'b1, 2'd2, 8'h00, 8'hAE},  // R2 frame loaded
    {1'b1, 1'b0, 2'd2, 8'h7A, 8'h00},  // R3 bits 6:4 ignored
    {1'b0, 1'b1, 2'd2, 8'h00, 8'h0A},  // R3
    {1'b0, 1'b1, 2'd1, 8'h00, 8'h00},  // R10 ctrl
    {1'b0, 1'b1, 2'd3, 8'h00, 8'h00},  // R10 unmapped
    {1'b1, 1'b0, 2'd1, 8'hFF, 8'h00},  // R10 ctrl write
    {1'b0, 1'b1, 2'd1, 8'h00, 8'h04}   // R10 only bit 2 stored
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic rd, input logic [1:0] a, input logic [7:0] d);
    bus_wr_en = wr; bus_rd_en = rd; bus_addr = a; bus_wdata = d;
  endtask

  function automatic int exp_bits(input logic [2:0] code);
    if (code == 3'b111) return 9;
    if (code[2]) return 8;
    return 5 + int'(code[1:0]);
  endfunction

  task automatic settle();
    drive(1'b0, 1'b0, 2'd0, 8'h00);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 baud", int'(baud_div), 0);
    chk("R1 sync", int'(sync_mode), 0);
    chk("R1 parity", int'(parity_mode), 0);
    chk("R1 stop", int'(two_stop), 0);
    chk("R1 bits", int'(data_bits), 8);
    chk("R1 pol", int'(clk_pol), 0);
    chk("R1 rdata", int'(bus_rdata), 0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19], VEC[i][18], VEC[i][17:16], VEC[i][15:8]);
      @(negedge clk);
      if (VEC[i][18]) chk($sformatf("vec%0d R5/R6/R7/R10", i), int'(bus_rdata), int'(VEC[i][7:0]));
    end
    settle();
    chk("R4 full divisor", int'(baud_div), 'hA67);
    chk("R9 ext+11 gives 9", int'(data_bits), 9);

    // R8: frame 0xAE with extension cleared
    drive(1'b1, 1'b0, 2'd1, 8'h00); @(negedge clk);
    drive(1'b1, 1'b0, 2'd2, 8'hAE); @(negedge clk);
    settle();
    chk("R8 sync", int'(sync_mode), 0);
    chk("R8 parity even", int'(parity_mode), 2);
    chk("R8 two stop", int'(two_stop), 1);
    chk("R8 bits", int'(data_bits), 8);
    chk("R8 pol", int'(clk_pol), 0);

    // R8 other fields: sync, odd parity, one stop, polarity
    drive(1'b1, 1'b0, 2'd2, 8'hF1); @(negedge clk);
    settle();
    chk("R8 sync set", int'(sync_mode), 1);
    chk("R8 parity odd", int'(parity_mode), 3);
    chk("R8 one stop", int'(two_stop), 0);
    chk("R8 pol set", int'(clk_pol), 1);
    chk("R8 size 00", int'(data_bits), 5);

    // R9 every size code
    for (int c = 0; c < 8; c++) begin
      drive(1'b1, 1'b0, 2'd1, 8'(c[2] << 2)); @(negedge clk);
      drive(1'b1, 1'b0, 2'd2, 8'h80 | 8'(c[1:0] << 1)); @(negedge clk);
      settle();
      chk($sformatf("R9 code %0d", c), int'(data_bits), exp_bits(3'(c)));
    end

    // R2: frame write leaves divisor; R3 max divisor
    drive(1'b1, 1'b0, 2'd0, 8'hFF); @(negedge clk);
    drive(1'b1, 1'b0, 2'd2, 8'h0F); @(negedge clk);
    drive(1'b1, 1'b0, 2'd2, 8'h80); @(negedge clk);
    settle();
    chk("R2/R4 divisor max 4095", int'(baud_div), 4095);

    // R1 reset again
    rst = 1'b1; @(negedge clk); @(negedge clk);
    rst = 1'b0; @(negedge clk);
    chk("R1 baud after reset", int'(baud_div), 0);
    chk("R1 bits after reset", int'(data_bits), 8);
    drive(1'b0, 1'b1, 2'd2, 8'h00); @(negedge clk);
    drive(1'b0, 1'b1, 2'd2, 8'h00);
    chk("R1 hi after reset", int'(bus_rdata), 0);
    @(negedge clk);
    chk("R1 frame after reset", int'(bus_rdata), 'h86);
    settle();
    finish_run();
  end
endmodule